// File: doc/BRIEF.md
# Multilane Deskew Release Controller

This block decides when the elastic buffers of several receive lanes may start handing user data onward, so that every lane begins at the same clock edge. Each lane reports the start of its first user-data multiframe with a one-cycle strobe. The controller records which lanes have arrived. It measures, against a local multiframe phase counter, how late the last lane turned up. It then asserts one read enable per lane, all in the same cycle.

The phase counter advances once per link-clock cycle. Each cycle carries four octets, so a multiframe of `MF_OCTETS` octets spans `MF_OCTETS/4` counts. A boundary pulse from the local multiframe clock returns the counter to zero.

In the buffered subclasses (any subclass code other than 0), release happens at the phase selected by a release-offset input. Zero means the multiframe boundary itself, and a nonzero value gives an earlier point inside the multiframe. If some lanes are still missing at that point, a sticky late flag is raised and the release waits for the next matching point. In subclass 0 the buffers are effectively bypassed: release follows the first frame-boundary pulse after the last lane has arrived.

Top module: `dsk_release_ctrl`

## Requirements
- R1: After reset all read enables are 0, `late_lane` is 0 and `arr_count` is 0.
- R2: The multiframe phase counter is 0 in any cycle with `lmfc_pulse` high. Otherwise it increments by one per clock and wraps from `MF_OCTETS/4-1` to 0; one count equals four octets.
- R3: A lane counts as arrived from the cycle after its first `lane_sof` strobe. Further strobes on that lane are ignored and do not change `arr_count`.
- R4: `arr_count` takes the phase value of the cycle in which the last missing lane's strobe is seen. It is visible from the next cycle and is held until reset.
- R5: When `subclass` is not 0, the release cycle is the first cycle after all lanes have arrived whose phase equals `rel_offset`. An offset of 0 is the multiframe boundary. Read enables rise in the cycle after the release cycle.
- R6: All bits of `lane_rd_en` are always equal, and once high they stay high until reset.
- R7: When `subclass` is 0, the release cycle is the first cycle after all lanes have arrived in which `frame_pulse` is high, whatever `rel_offset` holds.
- R8: When `subclass` is not 0, a cycle whose phase equals `rel_offset` in which at least one lane but not all lanes have arrived sets `late_lane`. The flag stays set until reset, and release moves to a later matching point.
- R9: A strobe seen in a release-point cycle does not make its lane count as arrived for that same point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, four octets per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| lmfc_pulse | input | 1 | Local multiframe boundary pulse |
| frame_pulse | input | 1 | Frame boundary pulse, used in subclass 0 |
| lane_sof | input | LANES | Per-lane start of first user-data multiframe strobe |
| subclass | input | 2 | Subclass code; 0 selects unbuffered release |
| rel_offset | input | CNT_W | Release phase in link-clock cycles, 0 = boundary |
| lane_rd_en | output | LANES | Per-lane buffer read enable |
| arr_count | output | CNT_W | Phase at which the latest lane arrived |
| late_lane | output | 1 | Sticky flag: a release point found lanes missing |

## Verification
A wrong arrival record shows at the ports as read enables that rise before the last lane has arrived, or never rise at all. It also shows as an `arr_count` that differs from the phase of the latest strobe, visible one cycle after that strobe. A phase counter that drifts from the boundary pulse moves the release edge away from the programmed offset. The error shows at the first release point, at most one multiframe after the last arrival. The bench compares every cycle's read enables and the final status against a timing model built from the lane strobe times, the offset and the subclass.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
   localparam int OCTETS_PER_CYCLE = 4;

   typedef enum logic [1:0] {
      SC_DIRECT = 2'd0,
      SC_DET_1  = 2'd1,
      SC_DET_2  = 2'd2,
      SC_RSVD   = 2'd3
   } subclass_e;

   function automatic int cnt_width(input int cycles);
      return (cycles <= 2) ? 1 : $clog2(cycles);
   endfunction

   function automatic logic is_buffered(input logic [1:0] sc);
      return sc != SC_DIRECT;
   endfunction
endpackage

// File: rtl/dsk_phase_cnt.sv
module dsk_phase_cnt #(
   parameter int CYCLES = 8,
   parameter int CNT_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lmfc_pulse,
   output logic [CNT_W-1:0] cur_phase
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

   generate
      if (CYCLES == 1) begin : g_single
         assign cur_phase = '0;
      end else begin : g_count
         logic [CNT_W-1:0] phase_q;
         always_comb begin
            if (lmfc_pulse)           cur_phase = '0;
            else if (phase_q == LAST) cur_phase = '0;
            else                      cur_phase = phase_q + 1'b1;
         end
         always_ff @(posedge clk) begin
            if (!rst_n) phase_q <= LAST;
            else        phase_q <= cur_phase;
         end
      end
   endgenerate
endmodule

// File: rtl/dsk_arrival.sv
module dsk_arrival #(
   parameter int LANES = 4,
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] lane_sof,
   input  logic [CNT_W-1:0] cur_phase,
   output logic             any_arr,
   output logic             all_arr,
   output logic [CNT_W-1:0] arr_count
);
   logic [LANES-1:0] seen_q;
   logic [CNT_W-1:0] count_q;
   logic             completes;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n)           seen_q[i] <= 1'b0;
         else if (lane_sof[i]) seen_q[i] <= 1'b1;
      end
   end

   assign completes = !(&seen_q) && (&(seen_q | lane_sof));

   always_ff @(posedge clk) begin
      if (!rst_n)         count_q <= '0;
      else if (completes) count_q <= cur_phase;
   end

   assign any_arr   = |seen_q;
   assign all_arr   = &seen_q;
   assign arr_count = count_q;
endmodule

// File: rtl/dsk_release.sv
module dsk_release #(
   parameter int LANES = 4,
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             any_arr,
   input  logic             all_arr,
   input  logic [CNT_W-1:0] cur_phase,
   input  logic [CNT_W-1:0] rel_offset,
   input  logic [1:0]       subclass,
   input  logic             frame_pulse,
   output logic [LANES-1:0] lane_rd_en,
   output logic             late_lane
);
   import dsk_pkg::*;

   logic go_q, late_q, buffered, at_point, fire;

   assign buffered = is_buffered(subclass);
   assign at_point = buffered ? (cur_phase == rel_offset) : frame_pulse;
   assign fire     = at_point && all_arr && !go_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         go_q   <= 1'b0;
         late_q <= 1'b0;
      end else begin
         if (fire) go_q <= 1'b1;
         if (buffered && at_point && any_arr && !all_arr) late_q <= 1'b1;
      end
   end

   assign lane_rd_en = {LANES{go_q}};
   assign late_lane  = late_q;
endmodule

// File: rtl/dsk_release_ctrl.sv
module dsk_release_ctrl #(
   parameter int LANES     = 4,
   parameter int MF_OCTETS = 32,
   localparam int LMFC_CYC = MF_OCTETS / dsk_pkg::OCTETS_PER_CYCLE,
   localparam int CNT_W    = dsk_pkg::cnt_width(LMFC_CYC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lmfc_pulse,
   input  logic             frame_pulse,
   input  logic [LANES-1:0] lane_sof,
   input  logic [1:0]       subclass,
   input  logic [CNT_W-1:0] rel_offset,
   output logic [LANES-1:0] lane_rd_en,
   output logic [CNT_W-1:0] arr_count,
   output logic             late_lane
);
   initial begin
      if (LANES < 1) $error("LANES must be at least 1");
      if (MF_OCTETS < 4 || (MF_OCTETS % dsk_pkg::OCTETS_PER_CYCLE) != 0)
         $error("MF_OCTETS must be a positive multiple of four");
   end

   logic [CNT_W-1:0] cur_phase;
   logic             any_arr, all_arr;

   dsk_phase_cnt #(.CYCLES(LMFC_CYC), .CNT_W(CNT_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .lmfc_pulse(lmfc_pulse), .cur_phase(cur_phase)
   );

   dsk_arrival #(.LANES(LANES), .CNT_W(CNT_W)) u_arr (
      .clk(clk), .rst_n(rst_n), .lane_sof(lane_sof), .cur_phase(cur_phase),
      .any_arr(any_arr), .all_arr(all_arr), .arr_count(arr_count)
   );

   dsk_release #(.LANES(LANES), .CNT_W(CNT_W)) u_rel (
      .clk(clk), .rst_n(rst_n), .any_arr(any_arr), .all_arr(all_arr),
      .cur_phase(cur_phase), .rel_offset(rel_offset), .subclass(subclass),
      .frame_pulse(frame_pulse), .lane_rd_en(lane_rd_en), .late_lane(late_lane)
   );
endmodule

// File: rtl/dsk_release_chk.sv
module dsk_release_chk #(
   parameter int LANES = 4,
   parameter int CNT_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lmfc_pulse,
   input logic             frame_pulse,
   input logic [1:0]       subclass,
   input logic [CNT_W-1:0] rel_offset,
   input logic [CNT_W-1:0] cur_phase,
   input logic             all_arr,
   input logic [LANES-1:0] lane_rd_en,
   input logic             late_lane
);
   a_r2_phase_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      lmfc_pulse |-> cur_phase == '0);

   a_r6_lanes_together: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_rd_en == '0) || (lane_rd_en == '1));

   a_r6_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      lane_rd_en[0] |=> lane_rd_en[0]);

   a_r5_after_arrival: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lane_rd_en[0]) |-> $past(all_arr));

   a_r5_offset_point: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(lane_rd_en[0]) && $past(subclass) != 2'd0) |-> $past(cur_phase) == $past(rel_offset));

   a_r7_frame_point: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(lane_rd_en[0]) && $past(subclass) == 2'd0) |-> $past(frame_pulse));

   a_r8_late_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      late_lane |=> late_lane);
endmodule

bind dsk_release_ctrl dsk_release_chk #(.LANES(LANES), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .lmfc_pulse(lmfc_pulse), .frame_pulse(frame_pulse),
   .subclass(subclass), .rel_offset(rel_offset), .cur_phase(cur_phase),
   .all_arr(all_arr), .lane_rd_en(lane_rd_en), .late_lane(late_lane)
);

// File: tb/sim_dsk_release_ctrl.sv
module sim_dsk_release_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int LANES = 4;
   localparam int MF = 32;
   localparam int PH = MF / 4;
   localparam int RUN = 40;
   localparam int NEVER = 999;

   logic clk = 0, rst_n = 0, lmfc_pulse = 0, frame_pulse = 0;
   logic [LANES-1:0] lane_sof = '0;
   logic [1:0] subclass = 0;
   logic [2:0] rel_offset = 0;
   logic [LANES-1:0] lane_rd_en;
   logic [2:0] arr_count;
   logic late_lane;

   int checks = 0, fails = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dsk_release_ctrl #(.LANES(LANES), .MF_OCTETS(MF)) u0 (
      .clk(clk), .rst_n(rst_n), .lmfc_pulse(lmfc_pulse), .frame_pulse(frame_pulse),
      .lane_sof(lane_sof), .subclass(subclass), .rel_offset(rel_offset),
      .lane_rd_en(lane_rd_en), .arr_count(arr_count), .late_lane(late_lane)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit is_point(int sc, int off, int m);
      return (sc != 0) ? ((m % PH) == off) : ((m % 2) == 0);
   endfunction

   function automatic int rel_cycle(int sc, int off, int last);
      if (last >= RUN) return -1;
      for (int m = last + 1; m < RUN; m++)
         if (is_point(sc, off, m)) return m;
      return -1;
   endfunction

   function automatic bit exp_late(int sc, int off, int first, int last);
      if (sc == 0) return 0;
      for (int m = first + 1; m < RUN && m <= last; m++)
         if ((m % PH) == off) return 1;
      return 0;
   endfunction

   task automatic scenario(input string tag, input int sc, input int off,
                           input int t[LANES], input int dup[LANES]);
      int first, last, rm;
      first = NEVER; last = 0;
      for (int i = 0; i < LANES; i++) begin
         if (t[i] < first) first = t[i];
         if (t[i] > last)  last  = t[i];
      end
      rm = rel_cycle(sc, off, last);
      @(negedge clk);
      rst_n = 0; lane_sof = '0; lmfc_pulse = 0; frame_pulse = 0;
      subclass = 2'(sc); rel_offset = 3'(off);
      repeat (2) @(negedge clk);
      chk("R1 rd_en", int'(lane_rd_en), 0);
      chk("R1 late", int'(late_lane), 0);
      chk("R1 arr_count", int'(arr_count), 0);
      rst_n = 1;
      for (int k = 0; k <= RUN; k++) begin
         if (k > 0) begin
            chk({"R6 together ", tag}, int'(lane_rd_en == '0 || lane_rd_en == '1), 1);
            chk({(sc != 0) ? "R5 R8 R9 release " : "R7 release ", tag},
                int'(lane_rd_en[0]), int'(rm >= 0 && k > rm));
            if (last < RUN && k > last)
               chk({"R3 R4 arr_count ", tag}, int'(arr_count), last % PH);
         end
         if (k == RUN) break;
         lmfc_pulse  = ((k % PH) == 0);
         frame_pulse = ((k % 2) == 0);
         for (int i = 0; i < LANES; i++)
            lane_sof[i] = (t[i] == k) || (dup[i] == k);
         @(negedge clk);
      end
      chk({"R8 late ", tag}, int'(late_lane), int'(exp_late(sc, off, first, last)));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      int t[LANES], d[LANES];
      void'($urandom(32'd5417));
      // R5: offset 0, skewed lanes, release at boundary 8 after last arrival 5
      t = '{1, 3, 5, 2};      d = '{NEVER, NEVER, NEVER, NEVER};
      scenario("off0", 1, 0, t, d);
      // R5: early release at phase 6 (cycle 6 > last 5)
      scenario("off6", 2, 6, t, d);
      // R8: release point phase 2 hits before lane 2 arrives
      scenario("late", 1, 2, t, d);
      // R9: last strobe lands on the release-point cycle itself
      t = '{0, 1, 4, 4};
      scenario("edge", 1, 4, t, d);
      // R3: repeated strobes are ignored for the arrival count
      t = '{2, 2, 6, 3};      d = '{9, 12, 14, NEVER};
      scenario("dup", 1, 3, t, d);
      // R7: subclass 0 uses frame pulses, offset ignored
      t = '{0, 6, 3, 1};      d = '{NEVER, NEVER, NEVER, NEVER};
      scenario("sc0", 0, 5, t, d);
      // R2 R4: all lanes arrive together at a phase past the wrap
      t = '{11, 11, 11, 11};
      scenario("sync", 1, 7, t, d);
      // R8: one lane never arrives, no release
      t = '{1, 2, NEVER, 3};
      scenario("miss", 1, 5, t, d);
      for (int n = 0; n < 24; n++) begin
         int sc, off;
         sc  = $urandom_range(0, 2);
         off = $urandom_range(0, PH - 1);
         for (int i = 0; i < LANES; i++) begin
            t[i] = $urandom_range(0, 20);
            d[i] = ($urandom_range(0, 3) == 0) ? t[i] + $urandom_range(1, 8) : NEVER;
         end
         scenario($sformatf("rnd%0d", n), sc, off, t, d);
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule